// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block keeps a small store of instruction bytes ready ahead of an instruction consumer. It forms a 20-bit fetch address from a 16-bit code segment and a 16-bit instruction pointer. It reads code from a 16-bit memory bus, normally two bytes per bus cycle, into a byte-wide first-in first-out queue. The consumer takes one byte at a time from the head of the queue.

One bus port is shared by the prefetch engine and by operand reads and writes that arrive from the execution side. A four-state machine settles who owns the bus. IDLE chooses the next cycle. FETCH runs a code fetch. DRAIN finishes a code fetch whose data has been invalidated by a branch. OPER runs an operand cycle. Its transitions are:
- IDLE to OPER when an operand request is pending.
- IDLE to FETCH when there is room in the queue and no operand request.
- IDLE stays in IDLE for one cycle when a branch arrives (branch hold), and whenever the queue has no room.
- FETCH to IDLE on completion.
- FETCH to DRAIN on a branch.
- DRAIN to IDLE on completion.
- OPER to IDLE on completion.

Loading a branch target empties the queue and starts fetching from the new address. A 2-bit status output reports each queue operation one cycle after it happens.

Top module: `pfq_unit`

## Requirements
- R1: The queue holds up to DEPTH (default 6) bytes and delivers them in the order they were fetched. `q_data` shows the head byte. `q_valid` is high whenever `q_level` is nonzero.
- R2: The fetch address is (segment × 16 + pointer) modulo 2^20. An even address fetches a word whose low lane (bits 7:0) is the byte at that address and whose high lane is the next byte. After each fetch the pointer advances by the number of bytes taken. The pointer wraps within 16 bits and the segment does not change. `bus_addr` holds steady while `bus_req` is high and `bus_done` is low.
- R3: A code fetch begins only when at least FREE_MIN (default 2) entries are free and `op_req` is low. With the queue holding more than DEPTH−FREE_MIN bytes and no operand request, `bus_req` stays low.
- R4: A code fetch that is in progress when `op_req` rises runs to completion first. The operand cycle follows it directly, with no further fetch in between.
- R5: Each accepted `pop` removes exactly one byte. A `pop` while the queue is empty changes nothing: the level stays 0 and the status reads 00. The consumer waits for the next byte.
- R6: A one-cycle `branch_load` pulse empties the queue and reloads the segment and pointer from `branch_cs` and `branch_ip`. In the following cycle `qstat` is 10 and `q_level` is 0. The first fetch after the pulse uses the new address.
- R7: When the fetch address is odd, `bus_byte` is high and only the byte on the high lane (bits 15:8) is queued. The next fetch is then word aligned.
- R8: A fetch in flight when a branch arrives is allowed to finish on the bus, but its data is discarded.
- R9: `qstat` is registered and valid the cycle after the queue operation it describes. The codes are:
  - 00: nothing happened.
  - 01: a pop with `pop_first` high.
  - 11: a pop with `pop_first` low.
  - 10: a flush.
- R10: An operand cycle drives `op_addr`, `op_we` and `op_wdata` on the bus with `bus_fetch` low. `op_done` pulses with `bus_done`, and `op_rdata` carries `bus_rdata`.
- R11: While `rst_n` is low:
  - the queue is empty;
  - `qstat` is 00;
  - `bus_req` is low;
  - the pointer takes RESET_CS/RESET_IP (default FFFF:0000, address FFFF0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| branch_load | input | 1 | Load a new fetch target and flush the queue |
| branch_cs | input | 16 | New code segment |
| branch_ip | input | 16 | New instruction pointer |
| pop | input | 1 | Consumer takes the head byte |
| pop_first | input | 1 | The popped byte starts an instruction |
| q_data | output | 8 | Head byte of the queue |
| q_valid | output | 1 | Queue holds at least one byte |
| q_level | output | 3 | Number of bytes held |
| qstat | output | 2 | Queue status of the previous cycle |
| op_req | input | 1 | Operand access request, held until op_done |
| op_we | input | 1 | Operand access is a write |
| op_addr | input | 20 | Operand address |
| op_wdata | input | 16 | Operand write data |
| op_done | output | 1 | Operand cycle completes this cycle |
| op_rdata | output | 16 | Operand read data |
| bus_req | output | 1 | Bus cycle requested |
| bus_fetch | output | 1 | Current bus cycle is a code fetch |
| bus_byte | output | 1 | Single-byte fetch on the high lane |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | 20 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_done | input | 1 | Bus cycle completes |
| bus_rdata | input | 16 | Bus read data |

## Verification
The bench builds the block with its default parameters: six entries, a fetch threshold of two free bytes, and a reset target of FFFF:0000. With these values the queue fills in three word fetches. Popping a single byte leaves exactly one free entry, which must not start a fetch. The reset address sits next to the top of the 20-bit space, so the wrap of the address sum and the 16-bit pointer wrap are reached with a few branch targets. A slow bus response from the bench keeps a fetch open long enough to land a branch or an operand request in the middle of it.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DRAIN = 2'd2,
        ST_OPER  = 2'd3
    } bus_st_e;

    typedef enum logic [1:0] {
        QS_NOP   = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

endpackage

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen #(
    parameter int          SEG_W    = 16,
    parameter int          OFF_W    = 16,
    parameter int          ADDR_W   = 20,
    parameter int          SHIFT    = 4,
    parameter logic [15:0] RESET_CS = 16'hFFFF,
    parameter logic [15:0] RESET_IP = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SEG_W-1:0]  load_cs,
    input  logic [OFF_W-1:0]  load_ip,
    input  logic              advance,
    input  logic              step_two,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              addr_odd
);
    logic [SEG_W-1:0] seg_q;
    logic [OFF_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= SEG_W'(RESET_CS);
            ptr_q <= OFF_W'(RESET_IP);
        end else if (load) begin
            seg_q <= load_cs;
            ptr_q <= load_ip;
        end else if (advance) begin
            ptr_q <= ptr_q + (step_two ? OFF_W'(2) : OFF_W'(1));
        end
    end

    always_comb begin
        phys_addr = ADDR_W'({seg_q, {SHIFT{1'b0}}}) + ADDR_W'(ptr_q);
        addr_odd  = ptr_q[0];
    end
endmodule

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo #(
    parameter int DEPTH = 6,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             pop,
    input  logic [1:0]       push_cnt,
    input  logic [7:0]       push_lo,
    input  logic [7:0]       push_hi,
    output logic [7:0]       head,
    output logic [LVL_W-1:0] level
);
    logic [DEPTH-1:0][7:0] mem_q;
    logic [DEPTH-1:0][7:0] mem_d;
    logic [LVL_W-1:0]      level_q;
    logic                  pop_ok;
    logic [LVL_W-1:0]      base;
    logic [LVL_W:0]        base1;

    always_comb begin
        pop_ok = pop && (level_q != '0);
        base   = level_q - LVL_W'(pop_ok);
        base1  = {1'b0, base} + (LVL_W+1)'(1);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [7:0] shifted;
        if (i == DEPTH - 1) begin : g_last
            assign shifted = mem_q[i];
        end else begin : g_mid
            assign shifted = pop_ok ? mem_q[i+1] : mem_q[i];
        end
        assign mem_d[i] =
            (LVL_W'(i) < base)                                 ? shifted :
            ((LVL_W'(i) == base) && (push_cnt != 2'd0))        ? push_lo :
            (((LVL_W+1)'(i) == base1) && (push_cnt == 2'd2))   ? push_hi :
                                                                 mem_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q   <= '0;
            level_q <= '0;
        end else if (flush) begin
            level_q <= '0;
        end else begin
            mem_q   <= mem_d;
            level_q <= level_q - LVL_W'(pop_ok) + LVL_W'(push_cnt);
        end
    end

    assign head  = mem_q[0];
    assign level = level_q;
endmodule

// File: rtl/pfq_bus_fsm.sv
module pfq_bus_fsm
    import pfq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_req,
    input  logic room_ok,
    input  logic branch_load,
    input  logic bus_done,
    output logic bus_req,
    output logic fetch_phase,
    output logic oper_phase,
    output logic fetch_accept,
    output logic idle_latch
);
    bus_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (branch_load)  state_d = ST_IDLE;
                else if (op_req)  state_d = ST_OPER;
                else if (room_ok) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (bus_done)         state_d = ST_IDLE;
                else if (branch_load) state_d = ST_DRAIN;
            end
            ST_DRAIN: if (bus_done) state_d = ST_IDLE;
            ST_OPER:  if (bus_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_req      = 1'b0;
        fetch_phase  = 1'b0;
        oper_phase   = 1'b0;
        fetch_accept = 1'b0;
        idle_latch   = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle_latch = 1'b1;
            ST_FETCH: begin
                bus_req      = 1'b1;
                fetch_phase  = 1'b1;
                fetch_accept = bus_done && !branch_load;
            end
            ST_DRAIN: begin
                bus_req     = 1'b1;
                fetch_phase = 1'b1;
            end
            ST_OPER: begin
                bus_req    = 1'b1;
                oper_phase = 1'b1;
            end
            default: idle_latch = 1'b1;
        endcase
    end
endmodule

// File: rtl/pfq_unit.sv
module pfq_unit
    import pfq_pkg::*;
#(
    parameter int          DEPTH    = 6,
    parameter int          FREE_MIN = 2,
    parameter int          SEG_W    = 16,
    parameter int          OFF_W    = 16,
    parameter int          ADDR_W   = 20,
    parameter int          DATA_W   = 16,
    parameter logic [15:0] RESET_CS = 16'hFFFF,
    parameter logic [15:0] RESET_IP = 16'h0000,
    localparam int         LVL_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              branch_load,
    input  logic [SEG_W-1:0]  branch_cs,
    input  logic [OFF_W-1:0]  branch_ip,
    input  logic              pop,
    input  logic              pop_first,
    output logic [7:0]        q_data,
    output logic              q_valid,
    output logic [LVL_W-1:0]  q_level,
    output logic [1:0]        qstat,
    input  logic              op_req,
    input  logic              op_we,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    output logic              op_done,
    output logic [DATA_W-1:0] op_rdata,
    output logic              bus_req,
    output logic              bus_fetch,
    output logic              bus_byte,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int ROOM_MAX = DEPTH - FREE_MIN;

    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_odd;
    logic              room_ok;
    logic              fetch_phase, oper_phase, fetch_accept, idle_latch;
    logic [ADDR_W-1:0] addr_q;
    logic              byte_q, we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        push_cnt;
    logic [7:0]        push_lo;
    logic              pop_eff;
    qstat_e            qstat_q;

    assign room_ok = (int'(q_level) <= ROOM_MAX);
    assign pop_eff = pop && !branch_load;

    pfq_addr_gen #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .SHIFT(4),
        .RESET_CS(RESET_CS), .RESET_IP(RESET_IP)
    ) addr_i (
        .clk(clk), .rst_n(rst_n),
        .load(branch_load), .load_cs(branch_cs), .load_ip(branch_ip),
        .advance(fetch_accept), .step_two(!byte_q),
        .phys_addr(fetch_addr), .addr_odd(fetch_odd)
    );

    pfq_bus_fsm fsm_i (
        .clk(clk), .rst_n(rst_n),
        .op_req(op_req), .room_ok(room_ok),
        .branch_load(branch_load), .bus_done(bus_done),
        .bus_req(bus_req), .fetch_phase(fetch_phase), .oper_phase(oper_phase),
        .fetch_accept(fetch_accept), .idle_latch(idle_latch)
    );

    // Capture the address and kind of the next bus cycle while idle, so
    // the bus stays stable even if the pointer is reloaded mid-cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            byte_q  <= 1'b0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (idle_latch) begin
            addr_q  <= op_req ? op_addr : fetch_addr;
            byte_q  <= !op_req && fetch_odd;
            we_q    <= op_req && op_we;
            wdata_q <= op_wdata;
        end
    end

    always_comb begin
        push_cnt = 2'd0;
        if (fetch_accept) push_cnt = byte_q ? 2'd1 : 2'd2;
        push_lo = byte_q ? bus_rdata[15:8] : bus_rdata[7:0];
    end

    pfq_byte_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) fifo_i (
        .clk(clk), .rst_n(rst_n),
        .flush(branch_load), .pop(pop_eff),
        .push_cnt(push_cnt), .push_lo(push_lo), .push_hi(bus_rdata[15:8]),
        .head(q_data), .level(q_level)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                         qstat_q <= QS_NOP;
        else if (branch_load)               qstat_q <= QS_FLUSH;
        else if (pop && (q_level != '0))    qstat_q <= pop_first ? QS_FIRST : QS_NEXT;
        else                                qstat_q <= QS_NOP;
    end

    assign qstat     = qstat_q;
    assign q_valid   = (q_level != '0);
    assign bus_fetch = fetch_phase;
    assign bus_byte  = fetch_phase && byte_q;
    assign bus_we    = oper_phase && we_q;
    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;
    assign op_done   = oper_phase && bus_done;
    assign op_rdata  = bus_rdata;
endmodule

// File: rtl/pfq_unit_chk.sv
module pfq_unit_chk #(
    parameter int DEPTH    = 6,
    parameter int FREE_MIN = 2,
    parameter int LVL_W    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             branch_load,
    input logic             op_req,
    input logic             pop,
    input logic             bus_req,
    input logic             bus_fetch,
    input logic             bus_byte,
    input logic             bus_done,
    input logic [19:0]      bus_addr,
    input logic [LVL_W-1:0] q_level,
    input logic [1:0]       qstat
);
    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_level) <= DEPTH);

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> $stable(bus_addr));

    p_fetch_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) && bus_fetch |->
            (int'($past(q_level)) <= DEPTH - FREE_MIN) && !$past(op_req));

    p_fetch_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_fetch && !bus_done |=> bus_req && bus_fetch);

    p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop && (q_level == '0) && !branch_load |=> qstat == 2'b00);

    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        branch_load |=> (qstat == 2'b10) && (q_level == '0));

    p_odd_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_fetch && bus_addr[0] |-> bus_byte);
endmodule

bind pfq_unit pfq_unit_chk #(.DEPTH(DEPTH), .FREE_MIN(FREE_MIN), .LVL_W(LVL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .branch_load(branch_load), .op_req(op_req),
    .pop(pop), .bus_req(bus_req), .bus_fetch(bus_fetch), .bus_byte(bus_byte),
    .bus_done(bus_done), .bus_addr(bus_addr), .q_level(q_level), .qstat(qstat)
);

// File: tb/pfq_unit_tb_top.sv
`timescale 1ns/1ps
module pfq_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        branch_load = 1'b0;
    logic [15:0] branch_cs = '0, branch_ip = '0;
    logic        pop = 1'b0, pop_first = 1'b0;
    logic [7:0]  q_data;
    logic        q_valid;
    logic [2:0]  q_level;
    logic [1:0]  qstat;
    logic        op_req = 1'b0, op_we = 1'b0;
    logic [19:0] op_addr = '0;
    logic [15:0] op_wdata = '0;
    logic        op_done;
    logic [15:0] op_rdata;
    logic        bus_req, bus_fetch, bus_byte, bus_we;
    logic [19:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_done = 1'b0;
    logic [15:0] bus_rdata = '0;

    int checks = 0, fails = 0;
    int lat = 1;
    int log_n = 0;
    logic [19:0] log_addr  [512];
    logic        log_fetch [512];
    logic        log_byte  [512];
    logic        log_we    [512];
    logic [15:0] log_wdata [512];
    logic        log_opd   [512];
    logic [15:0] log_ord   [512];

    always #4 clk = ~clk;

    pfq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .branch_load(branch_load),
        .branch_cs(branch_cs), .branch_ip(branch_ip),
        .pop(pop), .pop_first(pop_first), .q_data(q_data), .q_valid(q_valid),
        .q_level(q_level), .qstat(qstat),
        .op_req(op_req), .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata),
        .op_done(op_done), .op_rdata(op_rdata),
        .bus_req(bus_req), .bus_fetch(bus_fetch), .bus_byte(bus_byte),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_done(bus_done), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] bfn(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]};
    endfunction

    function automatic logic [15:0] wordf(input logic [19:0] a);
        return {bfn(a | 20'h1), bfn(a & ~20'h1)};
    endfunction

    // Memory model: responds lat cycles after a request, drives at negedge.
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                bus_done = 1'b0; cnt = 0;
            end else if (bus_done) begin
                bus_done = 1'b0; cnt = 0;
            end else if (bus_req) begin
                cnt++;
                if (cnt >= lat) begin
                    bus_rdata = wordf(bus_addr);
                    bus_done  = 1'b1;
                    #1;
                    if (log_n < 512) begin
                        log_addr[log_n]  = bus_addr;
                        log_fetch[log_n] = bus_fetch;
                        log_byte[log_n]  = bus_byte;
                        log_we[log_n]    = bus_we;
                        log_wdata[log_n] = bus_wdata;
                        log_opd[log_n]   = op_done;
                        log_ord[log_n]   = op_rdata;
                        log_n++;
                    end
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (40) step();
    endtask

    task automatic do_branch(input logic [15:0] cs, input logic [15:0] ip);
        branch_cs = cs; branch_ip = ip; branch_load = 1'b1;
        step();
        branch_load = 1'b0;
    endtask

    task automatic pop_byte(input bit first, output logic [7:0] d, output logic [1:0] qs);
        int t;
        t = 0;
        while (!q_valid && t < 500) begin step(); t++; end
        d = q_data; pop = 1'b1; pop_first = first;
        step();
        pop = 1'b0; pop_first = 1'b0;
        qs = qstat;
    endtask

    function automatic int find_addr(input int from, input logic [19:0] a);
        for (int k = from; k < log_n; k++) if (log_addr[k] == a) return k;
        return -1;
    endfunction

    task automatic t_reset();
        chk(bus_req == 1'b0, "R11 bus_req in reset", 32'(bus_req), 0);
        chk(q_valid == 1'b0 && q_level == 3'd0, "R11 queue empty in reset", 32'(q_level), 0);
        chk(qstat == 2'b00, "R11 qstat in reset", 32'(qstat), 0);
    endtask

    task automatic t_fill();
        logic [7:0] d; logic [1:0] qs;
        settle();
        chk(q_level == 3'd6, "R1 full level", 32'(q_level), 6);
        chk(bus_req == 1'b0, "R3 bus idle when full", 32'(bus_req), 0);
        chk(log_n == 3, "R2 three word fetches fill", 32'(log_n), 3);
        chk(log_addr[0] == 20'hFFFF0, "R11 R2 first fetch address", 32'(log_addr[0]), 32'hFFFF0);
        chk(log_addr[1] == 20'hFFFF2, "R2 pointer advances by two", 32'(log_addr[1]), 32'hFFFF2);
        pop_byte(1'b1, d, qs);
        chk(d == bfn(20'hFFFF0), "R1 head byte", 32'(d), 32'(bfn(20'hFFFF0)));
        chk(qs == 2'b01, "R9 first-byte status", 32'(qs), 1);
        repeat (10) step();
        chk(q_level == 3'd5 && log_n == 3, "R3 no fetch with one free entry", 32'(log_n), 3);
        chk(qstat == 2'b00, "R9 idle status", 32'(qstat), 0);
        pop_byte(1'b0, d, qs);
        chk(d == bfn(20'hFFFF1), "R1 second byte", 32'(d), 32'(bfn(20'hFFFF1)));
        chk(qs == 2'b11, "R9 subsequent-byte status", 32'(qs), 3);
        for (int k = 2; k < 12; k++) begin
            pop_byte(1'b0, d, qs);
            chk(d == bfn(20'hFFFF0 + 20'(k)), "R1 R2 byte order", 32'(d), 32'(bfn(20'hFFFF0 + 20'(k))));
        end
    endtask

    task automatic t_odd_branch();
        int k0, j; logic [7:0] d; logic [1:0] qs;
        lat = 2; settle();
        k0 = log_n;
        do_branch(16'h1000, 16'h0003);
        chk(qstat == 2'b10, "R6 flush status", 32'(qstat), 2);
        chk(q_level == 3'd0, "R6 queue emptied", 32'(q_level), 0);
        repeat (30) step();
        j = k0;
        chk(log_addr[j] == 20'h10003 && log_byte[j], "R7 odd single-byte fetch", 32'(log_addr[j]), 32'h10003);
        chk(log_addr[j+1] == 20'h10004 && !log_byte[j+1], "R7 aligned word follows", 32'(log_addr[j+1]), 32'h10004);
        for (int k = 0; k < 5; k++) begin
            pop_byte(1'b0, d, qs);
            chk(d == bfn(20'h10003 + 20'(k)), "R7 R6 stream from target", 32'(d), 32'(bfn(20'h10003 + 20'(k))));
        end
    endtask

    task automatic t_drain();
        int k0, j, t; logic [7:0] d; logic [1:0] qs;
        lat = 6; settle();
        k0 = log_n;
        do_branch(16'h2000, 16'h0000);
        t = 0;
        while (!(bus_req && bus_fetch) && t < 50) begin step(); t++; end
        do_branch(16'h3000, 16'h0010);
        chk(q_level == 3'd0, "R8 empty after flush", 32'(q_level), 0);
        for (int k = 0; k < 4; k++) begin
            pop_byte(1'b0, d, qs);
            chk(d == bfn(20'h30010 + 20'(k)), "R8 in-flight data dropped", 32'(d), 32'(bfn(20'h30010 + 20'(k))));
        end
        j = find_addr(k0, 20'h20000);
        chk(j >= 0, "R8 in-flight fetch completed", 32'(j), 0);
        if (j >= 0)
            chk(log_addr[j+1] == 20'h30010, "R8 next fetch at new target", 32'(log_addr[j+1]), 32'h30010);
    endtask

    task automatic t_empty_pop();
        logic [7:0] d; logic [1:0] qs;
        lat = 1; settle();
        lat = 40;
        do_branch(16'h5000, 16'h0000);
        for (int k = 0; k < 3; k++) begin
            pop = 1'b1; pop_first = 1'b1;
            step();
            pop = 1'b0; pop_first = 1'b0;
            chk(qstat == 2'b00, "R5 pop on empty status", 32'(qstat), 0);
            chk(q_level == 3'd0, "R5 pop on empty level", 32'(q_level), 0);
        end
        pop_byte(1'b1, d, qs);
        chk(d == bfn(20'h50000), "R5 waits for arriving byte", 32'(d), 32'(bfn(20'h50000)));
        lat = 1;
    endtask

    task automatic t_operand();
        int k0, j, t;
        lat = 4; settle();
        k0 = log_n;
        do_branch(16'h4000, 16'h0000);
        t = 0;
        while (!(bus_req && bus_fetch) && t < 50) begin step(); t++; end
        op_req = 1'b1; op_we = 1'b0; op_addr = 20'h12344; op_wdata = 16'h0;
        j = -1; t = 0;
        while (j < 0 && t < 100) begin
            step(); t++;
            for (int k = k0; k < log_n; k++) if (!log_fetch[k] && j < 0) j = k;
        end
        op_req = 1'b0;
        chk(j > k0, "R4 operand cycle seen after fetch", 32'(j), 32'(k0 + 1));
        if (j > k0) begin
            chk(log_addr[j-1] == 20'h40000 && log_fetch[j-1], "R4 in-flight fetch first", 32'(log_addr[j-1]), 32'h40000);
            chk(log_addr[j] == 20'h12344 && !log_we[j], "R10 operand read address", 32'(log_addr[j]), 32'h12344);
            chk(log_opd[j], "R10 op_done with bus_done", 32'(log_opd[j]), 1);
            chk(log_ord[j] == wordf(20'h12344), "R10 operand read data", 32'(log_ord[j]), 32'(wordf(20'h12344)));
        end
        settle();
        k0 = log_n;
        op_req = 1'b1; op_we = 1'b1; op_addr = 20'h00100; op_wdata = 16'hBEEF;
        t = 0;
        while (log_n == k0 && t < 100) begin step(); t++; end
        op_req = 1'b0; op_we = 1'b0;
        repeat (5) step();
        chk(log_n == k0 + 1, "R3 R10 only the operand cycle while full", 32'(log_n - k0), 1);
        chk(log_we[k0] && log_wdata[k0] == 16'hBEEF && log_addr[k0] == 20'h00100,
            "R10 operand write", 32'(log_wdata[k0]), 32'hBEEF);
        lat = 1;
    endtask

    task automatic t_wrap();
        int k0;
        lat = 1; settle();
        k0 = log_n;
        do_branch(16'hFFFF, 16'hFFF0);
        repeat (10) step();
        chk(log_addr[k0] == 20'h0FFE0, "R2 20-bit sum wraps", 32'(log_addr[k0]), 32'h0FFE0);
        settle();
        k0 = log_n;
        do_branch(16'hF000, 16'hFFFE);
        repeat (10) step();
        chk(log_addr[k0] == 20'hFFFFE, "R2 segment plus pointer", 32'(log_addr[k0]), 32'hFFFFE);
        chk(log_addr[k0+1] == 20'hF0000, "R2 pointer wraps in 16 bits", 32'(log_addr[k0+1]), 32'hF0000);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_fill();
        t_odd_branch();
        t_drain();
        t_empty_pop();
        t_operand();
        t_wrap();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule